// File: doc/BRIEF.md
# DMA Channel Trigger and Queueing

This block sits at the front of a DMA controller. It watches three ways a normal channel can be started: a hardware event line, a software event-set write, and a chained completion reported by the transfer side. It also watches a set of quick channels that start whenever the parameter set they point at is written. Every start sets one pending bit for its channel. A dispatcher picks the lowest-numbered pending channel, looks up its parameter-set index and its target queue in programmable tables, and pushes a transfer request into one of two event queues.

Each queue is a ready/valid FIFO. It reports its current level, a high-water mark and a flag that is high while the level is at or above a programmable threshold. A channel that is started again while it is still pending, or whose request finds its queue full, gets a sticky missed-event bit. The OR of all these bits drives the error interrupt. Every completion report raises a one-cycle completion interrupt.

The dispatcher is a two-state machine. In DSP_IDLE it waits for a pending channel. When it takes one it moves to DSP_ISSUE, and in that state it either pushes the request or drops it. The transition DSP_IDLE→DSP_ISSUE happens when any channel is pending. The transition DSP_ISSUE→DSP_IDLE happens after one cycle, every time.

Top module: `dma_trigger_queue`

## Requirements
- R1: A normal channel becomes pending, and later reaches a queue, in any of three ways: its `hw_evt` bit is high for a cycle; a config write uses op 0 (event set) with `cfg_idx` equal to the channel number; or `done_valid` and `done_chain` are high with `done_ch` naming the channel. A chained channel is pending one cycle after the report.
- R2: A config write with op 3 (parameter-set write) and `cfg_data[8:0]` = P starts every quick channel whose map entry equals P. A write with a P that no quick channel maps starts nothing.
- R3: A config write with op 1 stores `cfg_data[8:0]` as the parameter-set index of channel `cfg_idx`. Normal channels are numbered 0–63 and quick channels 64–71. After reset, every channel maps to the index equal to its own number. A queued entry carries the channel number on `q_chan` and the mapped index on `q_pset`.
- R4: When several channels are pending, the lowest channel number is queued first. Quick channels therefore follow all normal channels. At most one push happens per cycle.
- R5: A config write with op 2 sets the target queue of channel `cfg_idx` to `cfg_data[0]`. After reset, every channel targets queue 0.
- R6: Each queue holds up to 16 entries in arrival order. `q_valid` is high exactly when the level is non-zero. While an entry is offered and not accepted, the head entry stays unchanged.
- R7: A start for a channel that is already pending sets that channel's `miss_err` bit. A start that arrives in the very cycle the dispatcher takes the channel is not a miss: the channel becomes pending again. `irq_err` is the OR of all `miss_err` bits.
- R8: A request whose queue is full when it is issued is dropped. It sets the channel's `miss_err` bit and leaves the queue level unchanged.
- R9: A config write with op 5 clears `miss_err` of channel `cfg_idx`.
- R10: `q_hwm` holds the highest level seen since reset or since the last config write with op 6 to that queue (`cfg_idx` 0 or 1). Such a write loads the current level.
- R11: `q_over` is high while the level is at or above the threshold. A config write with op 4 sets the threshold of queue `cfg_idx` to `cfg_data[4:0]`. The threshold resets to 16.
- R12: `irq_done` is high for the cycle after each `done_valid` cycle. A report with `done_chain` low queues nothing.
- R13: After reset, no queue is valid, all levels and marks are 0, and no error or interrupt is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_evt | input | 64 | Hardware event per normal channel, one start per high cycle |
| cfg_wr | input | 1 | Config write strobe |
| cfg_sel | input | 3 | Write op: 0 event set, 1 map, 2 queue select, 3 parameter-set write, 4 threshold, 5 error clear, 6 mark clear |
| cfg_idx | input | 7 | Channel or queue index |
| cfg_data | input | 16 | Write data |
| done_valid | input | 1 | Completion report valid |
| done_ch | input | 6 | Channel named by the completion |
| done_chain | input | 1 | Start the named channel |
| q_valid | output | 2 | Per-queue entry offered |
| q_ready | input | 2 | Per-queue entry accepted |
| q_pset | output | 2x9 | Head entry parameter-set index per queue |
| q_chan | output | 2x7 | Head entry channel number per queue |
| q_level | output | 2x5 | Queue occupancy |
| q_hwm | output | 2x5 | Queue high-water mark |
| q_over | output | 2 | Level at or above threshold |
| miss_err | output | 72 | Sticky missed-event bit per channel |
| irq_done | output | 1 | Completion interrupt pulse |
| irq_err | output | 1 | Error interrupt level |

## Verification
Two things can fall into the same cycle here: the dispatcher taking a channel out of pending, and a fresh start for that same channel. The bench provokes this by pulsing a channel's event line on two consecutive cycles from an idle dispatcher. In that case the second pulse lands in the take cycle. The expected result is two queued entries and no miss bit. The contrasting case starts a lower channel alongside, so the second pulse meets a channel that is still pending, and that channel's miss bit must be set with only one entry queued.

// File: rtl/dma_trigger_queue_pkg.sv
package dma_trigger_queue_pkg;

    typedef enum logic [2:0] {
        CFG_EVT_SET = 3'd0,
        CFG_MAP     = 3'd1,
        CFG_QSEL    = 3'd2,
        CFG_PSET_WR = 3'd3,
        CFG_THR     = 3'd4,
        CFG_ERR_CLR = 3'd5,
        CFG_HWM_CLR = 3'd6,
        CFG_NOP     = 3'd7
    } cfg_op_e;

    typedef enum logic {
        DSP_IDLE  = 1'b0,
        DSP_ISSUE = 1'b1
    } dsp_state_e;

endpackage

// File: rtl/dma_trigger_queue_cfg.sv
module dma_trigger_queue_cfg
    import dma_trigger_queue_pkg::*;
#(
    parameter int NUM_CH   = 64,
    parameter int NUM_QCH  = 8,
    parameter int NUM_PSET = 512,
    parameter int Q_DEPTH  = 16,
    parameter int NUM_Q    = 2,
    parameter int DATA_W   = 16,
    localparam int NUM_TOT = NUM_CH + NUM_QCH,
    localparam int CH_W    = $clog2(NUM_TOT),
    localparam int PSET_W  = $clog2(NUM_PSET),
    localparam int LVL_W   = $clog2(Q_DEPTH + 1),
    localparam int QI_W    = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_wr,
    input  logic [2:0]                         cfg_sel,
    input  logic [CH_W-1:0]                    cfg_idx,
    input  logic [DATA_W-1:0]                  cfg_data,
    output logic [NUM_TOT-1:0][PSET_W-1:0]     chan_map,
    output logic [NUM_TOT-1:0][QI_W-1:0]       chan_q,
    output logic [NUM_Q-1:0][LVL_W-1:0]        q_thr
);

    cfg_op_e op;
    assign op = cfg_op_e'(cfg_sel);

    // channel tables: parameter-set index and target queue
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_TOT; i++) begin
                chan_map[i] <= PSET_W'(i);
                chan_q[i]   <= '0;
            end
        end else if (cfg_wr) begin
            for (int i = 0; i < NUM_TOT; i++) begin
                if (cfg_idx == CH_W'(i)) begin
                    if (op == CFG_MAP)  chan_map[i] <= cfg_data[PSET_W-1:0];
                    if (op == CFG_QSEL) chan_q[i]   <= cfg_data[QI_W-1:0];
                end
            end
        end
    end

    // per-queue occupancy thresholds
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int j = 0; j < NUM_Q; j++) q_thr[j] <= LVL_W'(Q_DEPTH);
        end else if (cfg_wr && op == CFG_THR) begin
            for (int j = 0; j < NUM_Q; j++)
                if (cfg_idx == CH_W'(j)) q_thr[j] <= cfg_data[LVL_W-1:0];
        end
    end

endmodule

// File: rtl/dma_trigger_queue_trig.sv
module dma_trigger_queue_trig
    import dma_trigger_queue_pkg::*;
#(
    parameter int NUM_CH   = 64,
    parameter int NUM_QCH  = 8,
    parameter int NUM_PSET = 512,
    parameter int DATA_W   = 16,
    localparam int NUM_TOT = NUM_CH + NUM_QCH,
    localparam int CH_W    = $clog2(NUM_TOT),
    localparam int DCH_W   = $clog2(NUM_CH),
    localparam int PSET_W  = $clog2(NUM_PSET)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_CH-1:0]              hw_evt,
    input  logic                           cfg_wr,
    input  logic [2:0]                     cfg_sel,
    input  logic [CH_W-1:0]                cfg_idx,
    input  logic [DATA_W-1:0]              cfg_data,
    input  logic                           done_valid,
    input  logic [DCH_W-1:0]               done_ch,
    input  logic                           done_chain,
    input  logic [NUM_TOT-1:0][PSET_W-1:0] chan_map,
    input  logic                           take_vld,
    input  logic [CH_W-1:0]                take_ch,
    input  logic                           drop_vld,
    input  logic [CH_W-1:0]                drop_ch,
    output logic [NUM_TOT-1:0]             pend,
    output logic [NUM_TOT-1:0]             miss
);

    cfg_op_e op;
    logic [NUM_TOT-1:0] start_v, take_v, drop_v, clr_v;

    assign op = cfg_op_e'(cfg_sel);

    always_comb begin
        start_v = '0;
        take_v  = '0;
        drop_v  = '0;
        clr_v   = '0;
        for (int i = 0; i < NUM_TOT; i++) begin
            if (cfg_wr && op == CFG_EVT_SET && cfg_idx == CH_W'(i)) start_v[i] = 1'b1;
            if (cfg_wr && op == CFG_ERR_CLR && cfg_idx == CH_W'(i)) clr_v[i]   = 1'b1;
            if (take_vld && take_ch == CH_W'(i)) take_v[i] = 1'b1;
            if (drop_vld && drop_ch == CH_W'(i)) drop_v[i] = 1'b1;
        end
        // normal channels: hardware line and chained completion
        for (int i = 0; i < NUM_CH; i++) begin
            if (hw_evt[i]) start_v[i] = 1'b1;
            if (done_valid && done_chain && done_ch == DCH_W'(i)) start_v[i] = 1'b1;
        end
        // quick channels: write to the parameter set they point at
        for (int k = 0; k < NUM_QCH; k++) begin
            if (cfg_wr && op == CFG_PSET_WR &&
                chan_map[NUM_CH+k] == cfg_data[PSET_W-1:0])
                start_v[NUM_CH+k] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= '0;
            miss <= '0;
        end else begin
            pend <= (pend & ~take_v) | start_v;
            miss <= (miss & ~clr_v) | (start_v & pend & ~take_v) | drop_v;
        end
    end

endmodule

// File: rtl/dma_trigger_queue_disp.sv
module dma_trigger_queue_disp
    import dma_trigger_queue_pkg::*;
#(
    parameter int NUM_CH   = 64,
    parameter int NUM_QCH  = 8,
    parameter int NUM_PSET = 512,
    parameter int NUM_Q    = 2,
    localparam int NUM_TOT = NUM_CH + NUM_QCH,
    localparam int CH_W    = $clog2(NUM_TOT),
    localparam int PSET_W  = $clog2(NUM_PSET),
    localparam int QI_W    = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
    localparam int ENT_W   = CH_W + PSET_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_TOT-1:0]             pend,
    input  logic [NUM_TOT-1:0][PSET_W-1:0] chan_map,
    input  logic [NUM_TOT-1:0][QI_W-1:0]   chan_q,
    input  logic [NUM_Q-1:0]               q_full,
    output logic                           take_vld,
    output logic [CH_W-1:0]                take_ch,
    output logic                           drop_vld,
    output logic [CH_W-1:0]                drop_ch,
    output logic [NUM_Q-1:0]               push,
    output logic [ENT_W-1:0]               push_data
);

    dsp_state_e          state, state_n;
    logic                win_any;
    logic [CH_W-1:0]     win_ch;
    logic [CH_W-1:0]     cur_ch;
    logic [PSET_W-1:0]   cur_pset;
    logic [QI_W-1:0]     cur_q;

    // lowest pending channel wins
    always_comb begin
        win_any = 1'b0;
        win_ch  = '0;
        for (int i = NUM_TOT - 1; i >= 0; i--) begin
            if (pend[i]) begin
                win_any = 1'b1;
                win_ch  = CH_W'(i);
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= DSP_IDLE;
        else        state <= state_n;
    end

    // transitions
    always_comb begin
        state_n = state;
        unique case (state)
            DSP_IDLE:  if (win_any) state_n = DSP_ISSUE;
            DSP_ISSUE: state_n = DSP_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        take_vld  = 1'b0;
        take_ch   = win_ch;
        drop_vld  = 1'b0;
        drop_ch   = cur_ch;
        push      = '0;
        push_data = {cur_ch, cur_pset};
        unique case (state)
            DSP_IDLE:  take_vld = win_any;
            DSP_ISSUE: begin
                for (int q = 0; q < NUM_Q; q++)
                    if (cur_q == QI_W'(q) && !q_full[q]) push[q] = 1'b1;
                drop_vld = q_full[cur_q];
            end
        endcase
    end

    // table lookup captured when a channel is taken
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_ch   <= '0;
            cur_pset <= '0;
            cur_q    <= '0;
        end else if (take_vld) begin
            cur_ch   <= win_ch;
            cur_pset <= chan_map[win_ch];
            cur_q    <= chan_q[win_ch];
        end
    end

endmodule

// File: rtl/dma_trigger_queue_fifo.sv
module dma_trigger_queue_fifo #(
    parameter int DEPTH  = 16,
    parameter int ENT_W  = 16,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [ENT_W-1:0] push_data,
    input  logic             ready,
    input  logic [LVL_W-1:0] thr,
    input  logic             hwm_clr,
    output logic             valid,
    output logic [ENT_W-1:0] head,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic [LVL_W-1:0] hwm,
    output logic             over
);

    logic [DEPTH-1:0][ENT_W-1:0] mem;
    logic [AW-1:0]               wr_ptr, rd_ptr;
    logic                        do_push, do_pop;

    assign valid   = (level != '0);
    assign full    = (level == LVL_W'(DEPTH));
    assign head    = mem[rd_ptr];
    assign over    = (level >= thr);
    assign do_push = push && !full;
    assign do_pop  = valid && ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem <= '0;
        end else if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            level <= level + LVL_W'(do_push) - LVL_W'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              hwm <= '0;
        else if (hwm_clr)        hwm <= level;
        else if (level > hwm)    hwm <= level;
    end

endmodule

// File: rtl/dma_trigger_queue.sv
module dma_trigger_queue
    import dma_trigger_queue_pkg::*;
#(
    parameter int NUM_CH   = 64,
    parameter int NUM_QCH  = 8,
    parameter int NUM_PSET = 512,
    parameter int Q_DEPTH  = 16,
    parameter int NUM_Q    = 2,
    parameter int DATA_W   = 16,
    localparam int NUM_TOT = NUM_CH + NUM_QCH,
    localparam int CH_W    = $clog2(NUM_TOT),
    localparam int DCH_W   = $clog2(NUM_CH),
    localparam int PSET_W  = $clog2(NUM_PSET),
    localparam int LVL_W   = $clog2(Q_DEPTH + 1),
    localparam int QI_W    = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
    localparam int ENT_W   = CH_W + PSET_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_CH-1:0]            hw_evt,
    input  logic                         cfg_wr,
    input  logic [2:0]                   cfg_sel,
    input  logic [CH_W-1:0]              cfg_idx,
    input  logic [DATA_W-1:0]            cfg_data,
    input  logic                         done_valid,
    input  logic [DCH_W-1:0]             done_ch,
    input  logic                         done_chain,
    output logic [NUM_Q-1:0]             q_valid,
    input  logic [NUM_Q-1:0]             q_ready,
    output logic [NUM_Q-1:0][PSET_W-1:0] q_pset,
    output logic [NUM_Q-1:0][CH_W-1:0]   q_chan,
    output logic [NUM_Q-1:0][LVL_W-1:0]  q_level,
    output logic [NUM_Q-1:0][LVL_W-1:0]  q_hwm,
    output logic [NUM_Q-1:0]             q_over,
    output logic [NUM_TOT-1:0]           miss_err,
    output logic                         irq_done,
    output logic                         irq_err
);

    logic [NUM_TOT-1:0][PSET_W-1:0] chan_map;
    logic [NUM_TOT-1:0][QI_W-1:0]   chan_q;
    logic [NUM_Q-1:0][LVL_W-1:0]    q_thr;
    logic [NUM_TOT-1:0]             pend;
    logic                           take_vld, drop_vld;
    logic [CH_W-1:0]                take_ch, drop_ch;
    logic [NUM_Q-1:0]               q_push, q_full;
    logic [ENT_W-1:0]               push_data;

    dma_trigger_queue_cfg #(
        .NUM_CH(NUM_CH), .NUM_QCH(NUM_QCH), .NUM_PSET(NUM_PSET),
        .Q_DEPTH(Q_DEPTH), .NUM_Q(NUM_Q), .DATA_W(DATA_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .chan_map(chan_map), .chan_q(chan_q), .q_thr(q_thr)
    );

    dma_trigger_queue_trig #(
        .NUM_CH(NUM_CH), .NUM_QCH(NUM_QCH), .NUM_PSET(NUM_PSET), .DATA_W(DATA_W)
    ) u_trig (
        .clk(clk), .rst_n(rst_n), .hw_evt(hw_evt),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .done_valid(done_valid), .done_ch(done_ch), .done_chain(done_chain),
        .chan_map(chan_map),
        .take_vld(take_vld), .take_ch(take_ch),
        .drop_vld(drop_vld), .drop_ch(drop_ch),
        .pend(pend), .miss(miss_err)
    );

    dma_trigger_queue_disp #(
        .NUM_CH(NUM_CH), .NUM_QCH(NUM_QCH), .NUM_PSET(NUM_PSET), .NUM_Q(NUM_Q)
    ) u_disp (
        .clk(clk), .rst_n(rst_n), .pend(pend),
        .chan_map(chan_map), .chan_q(chan_q), .q_full(q_full),
        .take_vld(take_vld), .take_ch(take_ch),
        .drop_vld(drop_vld), .drop_ch(drop_ch),
        .push(q_push), .push_data(push_data)
    );

    for (genvar g = 0; g < NUM_Q; g++) begin : g_queue
        logic             hwm_clr;
        logic [ENT_W-1:0] head;

        assign hwm_clr = cfg_wr && (cfg_op_e'(cfg_sel) == CFG_HWM_CLR) &&
                         (cfg_idx == CH_W'(g));

        dma_trigger_queue_fifo #(
            .DEPTH(Q_DEPTH), .ENT_W(ENT_W)
        ) u_fifo (
            .clk(clk), .rst_n(rst_n),
            .push(q_push[g]), .push_data(push_data),
            .ready(q_ready[g]), .thr(q_thr[g]), .hwm_clr(hwm_clr),
            .valid(q_valid[g]), .head(head), .level(q_level[g]),
            .full(q_full[g]), .hwm(q_hwm[g]), .over(q_over[g])
        );

        assign q_chan[g] = head[ENT_W-1:PSET_W];
        assign q_pset[g] = head[PSET_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_done <= 1'b0;
        else        irq_done <= done_valid;
    end

    assign irq_err = |miss_err;

endmodule

// File: rtl/dma_trigger_queue_chk.sv
module dma_trigger_queue_chk #(
    parameter int NUM_CH   = 64,
    parameter int NUM_QCH  = 8,
    parameter int NUM_PSET = 512,
    parameter int Q_DEPTH  = 16,
    parameter int NUM_Q    = 2,
    localparam int NUM_TOT = NUM_CH + NUM_QCH,
    localparam int CH_W    = $clog2(NUM_TOT),
    localparam int DCH_W   = $clog2(NUM_CH),
    localparam int PSET_W  = $clog2(NUM_PSET),
    localparam int LVL_W   = $clog2(Q_DEPTH + 1)
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         done_valid,
    input logic                         done_chain,
    input logic [DCH_W-1:0]             done_ch,
    input logic                         irq_done,
    input logic [NUM_Q-1:0]             q_valid,
    input logic [NUM_Q-1:0]             q_ready,
    input logic [NUM_Q-1:0][PSET_W-1:0] q_pset,
    input logic [NUM_Q-1:0][CH_W-1:0]   q_chan,
    input logic [NUM_Q-1:0][LVL_W-1:0]  q_level,
    input logic [NUM_Q-1:0][LVL_W-1:0]  q_hwm,
    input logic [NUM_TOT-1:0]           pend,
    input logic [NUM_Q-1:0]             push
);

    logic [DCH_W-1:0] last_done_ch;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_done_ch <= '0;
        else        last_done_ch <= done_ch;
    end

    assert_done_irq_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> irq_done);

    assert_chain_pend_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_chain) |=> pend[last_done_ch]);

    assert_single_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(push));

    for (genvar g = 0; g < NUM_Q; g++) begin : g_qchk
        assert_level_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
            q_level[g] <= LVL_W'(Q_DEPTH));

        assert_valid_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
            q_valid[g] == (q_level[g] != '0));

        assert_head_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (q_valid[g] && !q_ready[g]) |=>
                (q_valid[g] && $stable(q_pset[g]) && $stable(q_chan[g])));

        assert_hwm_cover_R10: assert property (@(posedge clk) disable iff (!rst_n)
            q_hwm[g] >= $past(q_level[g]));
    end

endmodule

bind dma_trigger_queue dma_trigger_queue_chk #(
    .NUM_CH(NUM_CH), .NUM_QCH(NUM_QCH), .NUM_PSET(NUM_PSET),
    .Q_DEPTH(Q_DEPTH), .NUM_Q(NUM_Q)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .done_valid(done_valid), .done_chain(done_chain), .done_ch(done_ch),
    .irq_done(irq_done),
    .q_valid(q_valid), .q_ready(q_ready), .q_pset(q_pset), .q_chan(q_chan),
    .q_level(q_level), .q_hwm(q_hwm),
    .pend(pend), .push(q_push)
);

// File: tb/dma_trigger_queue_test.sv
module dma_trigger_queue_test;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [63:0]      hw_evt = '0;
    logic             cfg_wr = 1'b0;
    logic [2:0]       cfg_sel = '0;
    logic [6:0]       cfg_idx = '0;
    logic [15:0]      cfg_data = '0;
    logic             done_valid = 1'b0;
    logic [5:0]       done_ch = '0;
    logic             done_chain = 1'b0;
    logic [1:0]       q_valid;
    logic [1:0]       q_ready = '0;
    logic [1:0][8:0]  q_pset;
    logic [1:0][6:0]  q_chan;
    logic [1:0][4:0]  q_level;
    logic [1:0][4:0]  q_hwm;
    logic [1:0]       q_over;
    logic [71:0]      miss_err;
    logic             irq_done;
    logic             irq_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 0;

    always #4 clk = ~clk;

    dma_trigger_queue uut (
        .clk(clk), .rst_n(rst_n), .hw_evt(hw_evt),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .done_valid(done_valid), .done_ch(done_ch), .done_chain(done_chain),
        .q_valid(q_valid), .q_ready(q_ready), .q_pset(q_pset), .q_chan(q_chan),
        .q_level(q_level), .q_hwm(q_hwm), .q_over(q_over),
        .miss_err(miss_err), .irq_done(irq_done), .irq_err(irq_err)
    );

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(int sel, int idx, int data);
        cfg_wr   = 1'b1;
        cfg_sel  = 3'(sel);
        cfg_idx  = 7'(idx);
        cfg_data = 16'(data);
        @(negedge clk);
        cfg_wr   = 1'b0;
    endtask

    task automatic pop(int q, int exp_ch, int exp_pset, string req);
        int waited = 0;
        while (!q_valid[q] && waited < 60) begin
            @(negedge clk);
            waited++;
        end
        check(req, "entry present", int'(q_valid[q]), 1);
        if (q_valid[q]) begin
            check(req, "channel", int'(q_chan[q]), exp_ch);
            check(req, "pset", int'(q_pset[q]), exp_pset);
            q_ready[q] = 1'b1;
            @(negedge clk);
            q_ready[q] = 1'b0;
        end
    endtask

    task automatic t_reset();
        check("R13", "q_valid", int'(q_valid), 0);
        check("R13", "level0", int'(q_level[0]), 0);
        check("R13", "hwm1", int'(q_hwm[1]), 0);
        check("R13", "miss_err", int'(miss_err != '0), 0);
        check("R13", "irq", int'({irq_done, irq_err}), 0);
        check("R11", "over at reset thr", int'(q_over), 0);
    endtask

    task automatic t_sources();
        cfg(0, 3, 0);                                  // R1 event-set write
        pop(0, 3, 3, "R1");
        hw_evt[7] = 1'b1; @(negedge clk); hw_evt[7] = 1'b0;
        pop(0, 7, 7, "R1");
        done_valid = 1'b1; done_ch = 6'd12; done_chain = 1'b1;
        @(negedge clk);
        check("R12", "irq_done pulse", int'(irq_done), 1);
        done_valid = 1'b0; done_chain = 1'b0;
        @(negedge clk);
        check("R12", "irq_done low", int'(irq_done), 0);
        pop(0, 12, 12, "R1");
        done_valid = 1'b1; done_ch = 6'd4; done_chain = 1'b0;
        @(negedge clk);
        done_valid = 1'b0;
        cyc(20);
        check("R12", "no chain no entry", int'(q_level[0]), 0);
    endtask

    task automatic t_priority();
        hw_evt[40] = 1'b1; hw_evt[5] = 1'b1;
        done_valid = 1'b1; done_ch = 6'd3; done_chain = 1'b1;
        cfg_wr = 1'b1; cfg_sel = 3'd0; cfg_idx = 7'd66;
        @(negedge clk);
        hw_evt = '0; done_valid = 1'b0; done_chain = 1'b0; cfg_wr = 1'b0;
        cyc(20);
        check("R4", "four queued", int'(q_level[0]), 4);
        pop(0, 3, 3, "R4");
        pop(0, 5, 5, "R4");
        pop(0, 40, 40, "R4");
        pop(0, 66, 66, "R4");
    endtask

    task automatic t_mapping();
        cfg(1, 9, 300);                                // R3 normal map
        cfg(1, 65, 7);                                 // quick 65 -> 7
        cfg(1, 70, 7);                                 // quick 70 -> 7
        cfg(0, 9, 0);
        pop(0, 9, 300, "R3");
        cfg(3, 0, 8);                                  // R2 unmapped write
        cyc(20);
        check("R2", "unmapped pset write", int'(q_level[0]), 0);
        cfg(3, 0, 7);
        pop(0, 65, 7, "R2");
        pop(0, 70, 7, "R2");
    endtask

    task automatic t_qsel();
        cfg(2, 20, 1);
        cfg(0, 20, 0);
        pop(1, 20, 20, "R5");
        check("R5", "queue0 untouched", int'(q_level[0]), 0);
    endtask

    task automatic t_miss();
        // retrigger in the take cycle: not a miss
        hw_evt[11] = 1'b1; @(negedge clk);
        @(negedge clk); hw_evt[11] = 1'b0;
        cyc(20);
        check("R7", "take-cycle retrigger no miss", int'(miss_err[11]), 0);
        pop(0, 11, 11, "R7");
        pop(0, 11, 11, "R7");
        // retrigger while still pending behind a lower channel
        hw_evt[10] = 1'b1; hw_evt[30] = 1'b1; @(negedge clk);
        hw_evt[10] = 1'b0; @(negedge clk);
        hw_evt[30] = 1'b0;
        cyc(20);
        check("R7", "pending retrigger miss", int'(miss_err[30]), 1);
        check("R7", "lower channel clean", int'(miss_err[10]), 0);
        check("R7", "irq_err", int'(irq_err), 1);
        check("R7", "one entry each", int'(q_level[0]), 2);
        pop(0, 10, 10, "R7");
        pop(0, 30, 30, "R7");
        cfg(5, 30, 0);
        @(negedge clk);
        check("R9", "miss cleared", int'(miss_err[30]), 0);
        check("R9", "irq_err cleared", int'(irq_err), 0);
    endtask

    task automatic t_levels();
        cfg(4, 0, 3);
        cfg(6, 0, 0);
        @(negedge clk);
        check("R10", "mark cleared", int'(q_hwm[0]), 0);
        cfg(0, 1, 0); cfg(0, 2, 0);
        cyc(20);
        check("R11", "below threshold", int'(q_over[0]), 0);
        cfg(0, 3, 0);
        cyc(20);
        check("R11", "at threshold", int'(q_over[0]), 1);
        pop(0, 1, 1, "R6"); pop(0, 2, 2, "R6"); pop(0, 3, 3, "R6");
        cfg(6, 0, 0);
        for (int c = 0; c < 16; c++) cfg(0, c, 0);
        cyc(40);
        check("R6", "full level", int'(q_level[0]), 16);
        check("R10", "mark at full", int'(q_hwm[0]), 16);
        cfg(0, 16, 0);
        cyc(20);
        check("R8", "drop sets miss", int'(miss_err[16]), 1);
        check("R8", "level unchanged", int'(q_level[0]), 16);
        for (int c = 0; c < 16; c++) pop(0, c, (c == 9) ? 300 : c, "R6");
        @(negedge clk);
        check("R6", "drained", int'(q_level[0]), 0);
        check("R11", "over low", int'(q_over[0]), 0);
        check("R10", "mark kept", int'(q_hwm[0]), 16);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_sources();
        t_priority();
        t_mapping();
        t_qsel();
        t_miss();
        t_levels();
        if (!done_flag) begin
            done_flag = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule